// File: doc/BRIEF.md
# Serial Gain-Word Load Port

This block receives an 8-bit gain code over a three-wire serial control port (serial clock, serial data, active-low load enable) and presents it as a held parallel word for a downstream variable-gain stage. All serial lines and an active-low power-down line are sampled in a faster system clock domain. The system clock must run at least four times faster than the serial clock.

Bits are collected into a shift register only while the load enable is low. During that time the output word keeps its previous value. When the load enable rises, the collected word is copied to the output holding stage and further shifting is blocked. Each serial bit is sampled when the serial clock rises and enters the shift register when the serial clock falls.

A one-cycle strobe marks a load that changed the code. A flag reports a load that did not carry exactly eight bits. A separate output-enable follows the power-down line and never disturbs the held code.

Top module: `gainword_port`

## Requirements
- R1: A synchronous active-high `rst` clears the gain code, the shift register, the bit count, `upd_stb` and `short_word` to 0.
- R2: The word is shifted most-significant bit first. After a load of eight bits and a rising `load_n`, `gain_code` equals the word, with the first bit sent at bit 7. Code 0 is minimum gain and code 255 is maximum gain.
- R3: While `load_n` is low, `gain_code` keeps the previously loaded value even as bits are shifted. The code changes only after a rising edge of `load_n`.
- R4: Each bit is the `ser_dat` value seen at the rising `ser_clk` edge. It enters the shift register at the following falling edge, so a data change between the two edges has no effect.
- R5: While `load_n` is high, `ser_clk` edges do not change the shift register. A later load with no bits reproduces the previous code.
- R6: `upd_stb` pulses for exactly one cycle after a rising `load_n` that changes `gain_code`. There is no pulse when the reloaded word equals the current code.
- R7: On each rising `load_n`, `short_word` becomes 1 if the number of bits shifted since the last falling `load_n` is not eight, and 0 otherwise. The transfer still uses the last eight bits held.
- R8: `pwr_n` low drives `out_en` low within three cycles, and `pwr_n` high drives it high again within three cycles. `gain_code` is unaffected by `pwr_n`, and loads still work while `out_en` is low.
- R9: If `load_n` is low when reset is released, `gain_code` stays at the minimum code 0 until the first rising `load_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low load enable; its rising edge transfers the word |
| pwr_n | input | 1 | Active-low power-down |
| gain_code | output | WORD_W | Held gain code |
| upd_stb | output | 1 | One-cycle pulse when a load changes the code |
| out_en | output | 1 | Output enable, low while powered down |
| short_word | output | 1 | The last load did not carry exactly eight bits |

## Verification
The bench flips the data line between the rising and falling serial clock edges. A design that samples data on the falling edge would load the complemented word. It pulses the serial clock with the load enable high and then runs an empty load. A design that still shifts in that state would change the code instead of reproducing it. It also reloads an identical word, which must give no strobe, and sends five-bit and ten-bit words. A design that counted wrongly or cleared the register would show the wrong flag or the wrong residual code. Finally, it releases reset with the enable low and loads a word while powered down. These catch a latch that is transparent at start-up and a power-down that disturbs the code.

// File: rtl/gw_pkg.sv
package gw_pkg;
  // positions of the raw control lines inside the synchroniser vector
  localparam int IX_SCLK = 0;
  localparam int IX_SDAT = 1;
  localparam int IX_EN   = 2;
  localparam int IX_PD   = 3;
  localparam int IN_N    = 4;
  // idle levels: enable and power-down high, clock and data low
  localparam logic [IN_N-1:0] IDLE_LVL = 4'b1100;
endpackage

// File: rtl/gw_sync.sv
module gw_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st1, st2;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1 <= RST_VAL;
      st2 <= RST_VAL;
    end else begin
      st1 <= d;
      st2 <= st1;
    end
  end

  assign q = st2;
endmodule

// File: rtl/gw_shifter.sv
module gw_shifter #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdat,
  input  logic              shift_ok,
  input  logic              cnt_clr,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  cnt
);
  logic             master;
  logic [CNT_W-1:0] cnt_base, cnt_nxt;
  logic             take, move;

  // saturating bit counter step
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == {CNT_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  // append one bit at the LSB end; the oldest bit moves toward the MSB
  function automatic logic [WORD_W-1:0] push(input logic [WORD_W-1:0] w,
                                             input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  assign take = shift_ok && sclk_rise;
  assign move = shift_ok && sclk_fall;

  always_comb begin
    cnt_base = cnt_clr ? '0 : cnt;
    cnt_nxt  = move ? bump(cnt_base) : cnt_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master <= 1'b0;
      word   <= '0;
      cnt    <= '0;
    end else begin
      if (take) master <= sdat;
      if (move) word <= push(word, master);
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/gw_hold.sv
module gw_hold #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_lvl,
  input  logic              en_rise,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] code,
  output logic              stb,
  output logic              short_w
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  function automatic logic is_short(input logic [CNT_W-1:0] c);
    return c != FULL;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      code    <= '0;
      stb     <= 1'b0;
      short_w <= 1'b0;
    end else begin
      stb <= en_rise && (word != code);
      if (en_rise) short_w <= is_short(cnt);
      // transparent while enable is high, frozen while low
      if (en_lvl) code <= word;
    end
  end
endmodule

// File: rtl/gainword_port.sv
module gainword_port #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              load_n,
  input  logic              pwr_n,
  output logic [WORD_W-1:0] gain_code,
  output logic              upd_stb,
  output logic              out_en,
  output logic              short_word
);
  import gw_pkg::*;

  localparam int CNT_W = $clog2(WORD_W) + 1;

  logic [IN_N-1:0]   raw_in, sync_in;
  logic              sclk_lvl, sdat_lvl, en_lvl, pd_lvl;
  logic              sclk_prev, en_prev, out_en_q;
  logic              sclk_rise, sclk_fall, en_rise, en_fall, shift_ok;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  always_comb begin
    raw_in          = '0;
    raw_in[IX_SCLK] = ser_clk;
    raw_in[IX_SDAT] = ser_dat;
    raw_in[IX_EN]   = load_n;
    raw_in[IX_PD]   = pwr_n;
  end

  gw_sync #(.W(IN_N), .RST_VAL(IDLE_LVL)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );

  assign sclk_lvl = sync_in[IX_SCLK];
  assign sdat_lvl = sync_in[IX_SDAT];
  assign en_lvl   = sync_in[IX_EN];
  assign pd_lvl   = sync_in[IX_PD];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= IDLE_LVL[IX_SCLK];
      en_prev   <= IDLE_LVL[IX_EN];
      out_en_q  <= IDLE_LVL[IX_PD];
    end else begin
      sclk_prev <= sclk_lvl;
      en_prev   <= en_lvl;
      out_en_q  <= pd_lvl;
    end
  end

  // named events for the checker
  assign sclk_rise = sclk_lvl & ~sclk_prev;
  assign sclk_fall = ~sclk_lvl & sclk_prev;
  assign en_rise   = en_lvl & ~en_prev;
  assign en_fall   = ~en_lvl & en_prev;
  assign shift_ok  = ~en_lvl;

  gw_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sdat(sdat_lvl), .shift_ok(shift_ok), .cnt_clr(en_fall),
    .word(shreg), .cnt(bit_cnt)
  );

  gw_hold #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst(rst), .en_lvl(en_lvl), .en_rise(en_rise),
    .word(shreg), .cnt(bit_cnt), .code(gain_code), .stb(upd_stb),
    .short_w(short_word)
  );

  assign out_en = out_en_q;
endmodule

// File: rtl/gw_check.sv
module gw_check #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en_rise,
  input logic              en_lvl,
  input logic [WORD_W-1:0] shreg,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [WORD_W-1:0] gain_code,
  input logic              upd_stb,
  input logic              short_word,
  input logic              out_en
);
  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (gain_code == '0) && !upd_stb && !short_word && (bit_cnt == '0));

  p_code_moves_on_load_r3: assert property (@(posedge clk) disable iff (rst)
    !en_rise |=> $stable(gain_code));

  p_no_shift_when_high_r5: assert property (@(posedge clk) disable iff (rst)
    en_lvl |=> $stable(shreg));

  p_strobe_on_change_r6: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (upd_stb == (gain_code != $past(gain_code))));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> !upd_stb);

  p_short_flag_r7: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (short_word == ($past(bit_cnt) != CNT_W'(WORD_W))));

  p_pd_keeps_code_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(out_en) |-> $stable(gain_code));
endmodule

bind gainword_port gw_check #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en_rise(en_rise), .en_lvl(en_lvl), .shreg(shreg),
  .bit_cnt(bit_cnt), .gain_code(gain_code), .upd_stb(upd_stb),
  .short_word(short_word), .out_en(out_en)
);

// File: tb/gainword_port_test.sv
module gainword_port_test;
  logic clk = 1'b0;
  logic rst, ser_clk, ser_dat, load_n, pwr_n;
  logic [7:0] gain_code;
  logic upd_stb, out_en, short_word;

  int total = 0, fails = 0, stb_cnt = 0;
  bit done = 1'b0;
  logic [7:0] model = 8'h00;

  always #2.5 clk = ~clk;

  gainword_port #(.WORD_W(8)) uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .load_n(load_n), .pwr_n(pwr_n), .gain_code(gain_code),
    .upd_stb(upd_stb), .out_en(out_en), .short_word(short_word)
  );

  always @(negedge clk) if (upd_stb) stb_cnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flip: change data between rising and falling serial clock edges
  task automatic shift_bits(input logic [15:0] bits, input int n, input bit flip);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      tick(2);
      ser_clk = 1'b1;
      tick(2);
      if (flip) ser_dat = ~bits[i];
      tick(2);
      ser_clk = 1'b0;
      tick(4);
      model = {model[6:0], bits[i]};
    end
  endtask

  task automatic load(input logic [15:0] bits, input int n, input bit flip,
                      input string tag);
    logic [7:0] prev;
    prev = gain_code;
    load_n = 1'b0;
    tick(4);
    shift_bits(bits, n, flip);
    stb_cnt = 0;
    load_n = 1'b1;
    tick(8);
    chk(gain_code == model, {tag, " code"}, gain_code, model);
    chk(stb_cnt == ((model != prev) ? 1 : 0), {tag, " strobe R6"}, stb_cnt,
        (model != prev) ? 1 : 0);
    chk(short_word == (n != 8), {tag, " short R7"}, short_word, (n != 8));
  endtask

  task automatic t_powerup_low;   // R1, R9
    rst = 1'b1; load_n = 1'b0; pwr_n = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(12);
    chk(gain_code == 8'h00, "R1 reset code", gain_code, 0);
    chk(stb_cnt == 0, "R1 no strobe", stb_cnt, 0);
    chk(short_word == 1'b0, "R1 short clear", short_word, 0);
    chk(out_en == 1'b1, "R8 out_en idle", out_en, 1);
    shift_bits(16'h00FF, 8, 1'b0);
    chk(gain_code == 8'h00, "R9 min code held while low", gain_code, 0);
    stb_cnt = 0;
    load_n = 1'b1;
    tick(8);
    chk(gain_code == 8'hFF, "R2 max code", gain_code, 8'hFF);
    chk(stb_cnt == 1, "R6 strobe on change", stb_cnt, 1);
  endtask

  task automatic t_hold_mid;   // R3
    logic [7:0] prev;
    prev = gain_code;
    load_n = 1'b0;
    tick(4);
    shift_bits(16'h000A, 4, 1'b0);
    chk(gain_code == prev, "R3 hold mid word", gain_code, prev);
    shift_bits(16'h0005, 4, 1'b0);
    chk(gain_code == prev, "R3 hold full word", gain_code, prev);
    load_n = 1'b1;
    tick(8);
    chk(gain_code == 8'hA5, "R2 msb first", gain_code, 8'hA5);
  endtask

  task automatic t_ignore_high;   // R5
    ser_dat = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ser_clk = 1'b1; tick(4); ser_clk = 1'b0; tick(4);
    end
    chk(gain_code == model, "R5 code after clocks while high", gain_code, model);
    load(16'h0000, 0, 1'b0, "R5 empty load");
  endtask

  task automatic t_powerdown;   // R8
    logic [7:0] prev;
    prev = gain_code;
    pwr_n = 1'b0;
    tick(4);
    chk(out_en == 1'b0, "R8 out_en low", out_en, 0);
    chk(gain_code == prev, "R8 code kept", gain_code, prev);
    load(16'h005A, 8, 1'b0, "R8 load while down");
    pwr_n = 1'b1;
    tick(4);
    chk(out_en == 1'b1, "R8 out_en high", out_en, 1);
    chk(gain_code == 8'h5A, "R8 code after power up", gain_code, 8'h5A);
  endtask

  initial begin
    t_powerup_low();
    t_hold_mid();
    load(16'h003C, 8, 1'b0, "R2 word 3C");
    load(16'h003C, 8, 1'b0, "R6 same word");
    t_ignore_high();
    load(16'h0081, 8, 1'b1, "R4 rise sample");
    load(16'h0016, 5, 1'b0, "R7 five bits");
    load(16'h02C3, 10, 1'b0, "R7 ten bits");
    load(16'h0000, 8, 1'b0, "R2 min code");
    t_powerdown();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk(gain_code == 8'h00, "R1 reset after use", gain_code, 0);
    chk(short_word == 1'b0, "R1 short after reset", short_word, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
      $finish;
    end
  end
endmodule